// File: doc/BRIEF.md
# Pulser Program Selection Controller

This block is the operator control state machine in front of a four-channel ultrasound pulser pattern generator. It receives three single-cycle, already debounced button pulses (select-next, run, abort) and a completion pulse from the waveform engines. From these it keeps the index of the selected preset and a run enable for the engines. It also drives status lamps: one for idle, one for a started run, one for a stopped run, and a one-hot lamp vector for the selected preset.

The operator steps through the presets while idle and then launches the selected one. A pulse-wave preset finishes by itself and returns the controller to idle. The continuous-wave preset keeps running until the abort button is pressed. An abort always ends the run at once, raises the stopped lamp and sends a one-cycle clamp request to the channel outputs. After any run the same preset can be launched again without being selected again.

Top module: `pulser_select_ctrl`

## Requirements
- R1: After a synchronous active-low reset the controller is idle with preset index 0: `led_idle`=1, `run_en`=0, `led_start`=0, `led_stop`=0, `force_clamp`=0, `led_prog`=1 (bit 0).
- R2: A `btn_prog` pulse while idle advances `prog_idx` by one on the next clock, and `led_prog` always has exactly the bit at position `prog_idx` set.
- R3: The selection wraps from index NUM_PROGS-1 (5 by default) back to 0.
- R4: A `btn_start` pulse while idle sets `run_en`=1, `led_idle`=0 and `led_start`=1 and clears `led_stop` on the next clock. If `btn_start` and `btn_prog` arrive in the same cycle, the start is taken and the selection does not change.
- R5: While a pulse-wave preset (any index other than CW_PROG) runs, a `pat_done` pulse returns the controller to idle on the next clock, and `led_start` stays on.
- R6: While the continuous-wave preset (index CW_PROG, 2 by default) runs, `pat_done` has no effect. Only `btn_stop` ends the run.
- R7: A `btn_stop` pulse during any run returns the controller to idle on the next clock, sets `led_stop` and raises `force_clamp` for exactly one cycle. If it arrives together with `pat_done`, the stop takes precedence.
- R8: `btn_prog` is ignored while running (the index holds), and `btn_stop` is ignored while idle (no lamp or clamp change).
- R9: A `btn_prog` pulse while idle clears both `led_start` and `led_stop`.
- R10: After a run ends, `btn_start` relaunches the same preset index without reselection.
- R11: `led_idle` and `run_en` are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_prog | input | 1 | Select-next-preset pulse |
| btn_start | input | 1 | Run pulse |
| btn_stop | input | 1 | Abort pulse |
| pat_done | input | 1 | Pattern complete pulse from waveform engines |
| prog_idx | output | $clog2(NUM_PROGS) | Selected preset index |
| run_en | output | 1 | Waveform engines enabled |
| force_clamp | output | 1 | One-cycle request to clamp all channel outputs after an abort |
| led_idle | output | 1 | Idle lamp |
| led_start | output | 1 | Run-started lamp |
| led_stop | output | 1 | Run-stopped lamp |
| led_prog | output | NUM_PROGS | One-hot selected-preset lamps |

## Verification
The bench builds the block with its defaults: six presets and the continuous-wave preset at index 2. With these, both the wrap from 5 to 0 and the done-ignoring preset can be reached in a few presses. A single table walks reselection, continuous and finite runs, abort with and without a coincident done, relaunch and simultaneous button presses. A directed reset in the middle of a run then confirms that every output returns to its initial value.

// File: rtl/pss_pkg.sv
// Shared types for the pulser program selection controller.
// Assumes nothing beyond a two-state run/idle control model.
package pss_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pss_state_e;
endpackage

// File: rtl/pss_sel.sv
// Preset selection register: holds the selected index and advances it,
// wrapping at NUM_PROGS-1. Assumes 'adv' is already gated to idle-only.
module pss_sel #(
    parameter int NUM_PROGS = 6,
    parameter int IDX_W     = $clog2(NUM_PROGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] sel
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PROGS - 1);

    // Advance or wrap the selection on each qualified press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (adv) begin
            sel <= (sel == LAST) ? '0 : sel + 1'b1;
        end
    end
endmodule

// File: rtl/pss_fsm.sv
// Run control state machine: launches a preset, ends it on completion
// (finite presets only) or on abort, and keeps the start/stop lamps.
// Assumes single-cycle button and done pulses.
module pss_fsm
    import pss_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int CW_PROG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_prog,
    input  logic             btn_start,
    input  logic             btn_stop,
    input  logic             pat_done,
    input  logic [IDX_W-1:0] sel,
    output pss_state_e       state,
    output logic             adv,
    output logic             lamp_start,
    output logic             lamp_stop,
    output logic             clamp
);
    localparam logic [IDX_W-1:0] CW_IDX = IDX_W'(CW_PROG);

    logic is_idle;
    logic finite_done;

    // Decode qualified events for the current state.
    always_comb begin
        is_idle     = (state == ST_IDLE);
        adv         = is_idle && btn_prog && !btn_start;
        finite_done = pat_done && (sel != CW_IDX);
    end

    // State, lamp and clamp-request updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lamp_start <= 1'b0;
            lamp_stop  <= 1'b0;
            clamp      <= 1'b0;
        end else begin
            clamp <= 1'b0;
            if (is_idle) begin
                if (btn_start) begin
                    state      <= ST_RUN;
                    lamp_start <= 1'b1;
                    lamp_stop  <= 1'b0;
                end else if (btn_prog) begin
                    lamp_start <= 1'b0;
                    lamp_stop  <= 1'b0;
                end
            end else begin
                if (btn_stop) begin
                    state     <= ST_IDLE;
                    lamp_stop <= 1'b1;
                    clamp     <= 1'b1;
                end else if (finite_done) begin
                    state <= ST_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/pss_led.sv
// One-hot lamp decoder for the selected preset index.
// Assumes sel < NUM_PROGS.
module pss_led #(
    parameter int NUM_PROGS = 6,
    parameter int IDX_W     = $clog2(NUM_PROGS)
) (
    input  logic [IDX_W-1:0]     sel,
    output logic [NUM_PROGS-1:0] lamps
);
    for (genvar g = 0; g < NUM_PROGS; g++) begin : g_lamp
        // Light lamp g when preset g is selected.
        always_comb lamps[g] = (sel == IDX_W'(g));
    end
endmodule

// File: rtl/pulser_select_ctrl.sv
// Top of the pulser program selection controller: ties the selection
// register, run state machine and lamp decoder together.
// Assumes debounced single-cycle inputs in the clk domain.
module pulser_select_ctrl
    import pss_pkg::*;
#(
    parameter int NUM_PROGS = 6,
    parameter int CW_PROG   = 2,
    localparam int IDX_W    = $clog2(NUM_PROGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 btn_prog,
    input  logic                 btn_start,
    input  logic                 btn_stop,
    input  logic                 pat_done,
    output logic [IDX_W-1:0]     prog_idx,
    output logic                 run_en,
    output logic                 force_clamp,
    output logic                 led_idle,
    output logic                 led_start,
    output logic                 led_stop,
    output logic [NUM_PROGS-1:0] led_prog
);
    pss_state_e       state;
    logic             adv;
    logic [IDX_W-1:0] sel;

    pss_sel #(.NUM_PROGS(NUM_PROGS), .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .adv(adv), .sel(sel)
    );

    pss_fsm #(.IDX_W(IDX_W), .CW_PROG(CW_PROG)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .btn_prog(btn_prog), .btn_start(btn_start), .btn_stop(btn_stop),
        .pat_done(pat_done), .sel(sel), .state(state), .adv(adv),
        .lamp_start(led_start), .lamp_stop(led_stop), .clamp(force_clamp)
    );

    pss_led #(.NUM_PROGS(NUM_PROGS), .IDX_W(IDX_W)) u_led (
        .sel(sel), .lamps(led_prog)
    );

    // Drive status outputs from state and selection.
    always_comb begin
        prog_idx = sel;
        run_en   = (state == ST_RUN);
        led_idle = (state == ST_IDLE);
    end
endmodule

// File: rtl/pulser_select_ctrl_chk.sv
// Property checker for pulser_select_ctrl, bound to every instance.
module pulser_select_ctrl_chk #(
    parameter int NUM_PROGS = 6,
    parameter int CW_PROG   = 2,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 btn_prog,
    input logic                 btn_start,
    input logic                 btn_stop,
    input logic                 pat_done,
    input logic [IDX_W-1:0]     prog_idx,
    input logic                 run_en,
    input logic                 force_clamp,
    input logic                 led_idle,
    input logic                 led_start,
    input logic                 led_stop,
    input logic [NUM_PROGS-1:0] led_prog
);
    AST_IDLE_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        led_idle != run_en); // R11
    AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(led_prog) == 1 && led_prog[prog_idx]); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (led_idle && btn_prog && !btn_start && prog_idx == IDX_W'(NUM_PROGS - 1))
        |=> prog_idx == '0); // R3
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (led_idle && btn_start) |=> (run_en && led_start && !led_stop)); // R4
    AST_CW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && prog_idx == IDX_W'(CW_PROG) && !btn_stop) |=> run_en); // R6
    AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && btn_stop) |=> (led_idle && led_stop && force_clamp)); // R7
    AST_CLAMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        force_clamp |=> !force_clamp); // R7
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(prog_idx)); // R8
endmodule

bind pulser_select_ctrl pulser_select_ctrl_chk #(
    .NUM_PROGS(NUM_PROGS), .CW_PROG(CW_PROG), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/test_pulser_select_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed reset cases.
module test_pulser_select_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_prog = 1'b0, btn_start = 1'b0, btn_stop = 1'b0, pat_done = 1'b0;
    logic [2:0] prog_idx;
    logic       run_en, force_clamp, led_idle, led_start, led_stop;
    logic [5:0] led_prog;

    int checks = 0;
    int errors = 0;

    pulser_select_ctrl i_pulser_select_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_prog(btn_prog), .btn_start(btn_start),
        .btn_stop(btn_stop), .pat_done(pat_done), .prog_idx(prog_idx),
        .run_en(run_en), .force_clamp(force_clamp), .led_idle(led_idle),
        .led_start(led_start), .led_stop(led_stop), .led_prog(led_prog)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {prog,start,stop,done, exp_idle,exp_start,exp_stop,exp_clamp, exp_idx[2:0]}
    localparam logic [10:0] VEC [NV] = '{
        11'b1000_1000_001, // 0  R2 advance to 1
        11'b1000_1000_010, // 1  R2 advance to 2 (continuous preset)
        11'b0100_0100_010, // 2  R4 start
        11'b0001_0100_010, // 3  R6 done ignored on continuous preset
        11'b1000_0100_010, // 4  R8 select ignored while running
        11'b0010_1111_010, // 5  R7 stop ends continuous run, clamp pulse
        11'b0000_1110_010, // 6  R7 clamp drops after one cycle
        11'b0100_0100_010, // 7  R10 relaunch same preset, R4 clears stop lamp
        11'b0010_1111_010, // 8  R7 stop again
        11'b1000_1000_011, // 9  R9 select clears lamps, index 3
        11'b0100_0100_011, // 10 R4 start finite preset
        11'b0001_1100_011, // 11 R5 finite completes, start lamp stays
        11'b0100_0100_011, // 12 R10 relaunch
        11'b0011_1111_011, // 13 R7 stop wins over done
        11'b1000_1000_100, // 14 R2 index 4
        11'b1000_1000_101, // 15 R2 index 5
        11'b1000_1000_000, // 16 R3 wrap to 0
        11'b1100_0100_000, // 17 R4 start wins over select
        11'b0000_0100_000, // 18 R5 run holds without done
        11'b0001_1100_000, // 19 R5 finite done
        11'b0010_1100_000  // 20 R8 stop ignored in idle
    };

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic check_reset_state();
        check("R1 led_idle", int'(led_idle), 1);
        check("R1 run_en", int'(run_en), 0);
        check("R1 led_start", int'(led_start), 0);
        check("R1 led_stop", int'(led_stop), 0);
        check("R1 force_clamp", int'(force_clamp), 0);
        check("R1 prog_idx", int'(prog_idx), 0);
        check("R1 led_prog", int'(led_prog), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {btn_prog, btn_start, btn_stop, pat_done} = VEC[i][10:7];
            @(posedge clk);
            @(negedge clk);
            {btn_prog, btn_start, btn_stop, pat_done} = 4'b0000;
            check($sformatf("R4 R5 R6 R7 R11 idle v%0d", i), int'(led_idle), int'(VEC[i][6]));
            check($sformatf("R11 run_en v%0d", i), int'(run_en), int'(!VEC[i][6]));
            check($sformatf("R4 R9 led_start v%0d", i), int'(led_start), int'(VEC[i][5]));
            check($sformatf("R7 R9 led_stop v%0d", i), int'(led_stop), int'(VEC[i][4]));
            check($sformatf("R7 force_clamp v%0d", i), int'(force_clamp), int'(VEC[i][3]));
            check($sformatf("R2 R3 R8 prog_idx v%0d", i), int'(prog_idx), int'(VEC[i][2:0]));
            check($sformatf("R2 led_prog v%0d", i), int'(led_prog), 1 << VEC[i][2:0]);
        end
        // Directed: reset in the middle of a run on a nonzero preset (R1)
        btn_prog = 1'b1;
        @(posedge clk); @(negedge clk);
        btn_prog = 1'b0; btn_start = 1'b1;
        @(posedge clk); @(negedge clk);
        btn_start = 1'b0;
        check("R4 directed run", int'(run_en), 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        // Directed: done while idle has no effect (R8 idle hold)
        pat_done = 1'b1;
        @(posedge clk); @(negedge clk);
        pat_done = 1'b0;
        check("R8 done in idle", int'(led_idle), 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule